// File: doc/BRIEF.md
# TLB Array Register Window

This block lets software, over a simple request/response register bus, read and write the stored entries of two translation buffers: a small instruction buffer (4 entries by default) and a larger unified buffer (64 entries by default). Each bus address selects one buffer, one of its arrays (the tag array or one of the two attribute arrays) and an entry index. The 32-bit bus word is split into entry fields on a write and assembled from them on a read. Bits that hold no stored field read back as zero.

Two side effects go with each access. First, every accepted access to the unified buffer, read or write, moves a replacement counter forward. The counter wraps at the last entry or at a boundary value that can be programmed. Second, when a write changes the tag or the first attribute word of an entry that is currently valid, the block raises a one-cycle invalidate notice that carries the entry's old virtual page number. Downstream cached translations can then be dropped.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, reads and writes alike, gets exactly one response on the following cycle. The block holds one response at most: while a response waits with `rsp_ready` low, `req_ready` stays low and `rsp_data` does not change.

Top module: `tlbp_array_port`

## Requirements
- R1: Address decode. `req_addr[25:24]` picks the array: 0 is the instruction tag array, 1 is the instruction attribute arrays, 2 is the unified tag array, 3 is the unified attribute arrays. For attribute arrays, `req_addr[23]` set selects the second attribute word and clear selects the first. The entry index is `req_addr[9:8]` for the instruction buffer and `req_addr[13:8]` for the unified buffer. All other address bits are ignored.
- R2: Tag word, for both buffers: page number in bits 31:10, valid in bit 8, address-space ID in bits 7:0. Bit 9 reads as zero.
- R3: Unified first attribute word: physical page in bits 28:10, valid in bit 8, size high bit in bit 7, protection in bits 6:5, size low bit in bit 4, cacheable in bit 3, dirty in bit 2, shared in bit 1, write-through in bit 0. Bits 31:29 and bit 9 read as zero.
- R4: Instruction first attribute word: same layout as R3, except that only protection bit 6 is stored. Bits 5, 2 and 0 read as zero even after they are written as one.
- R5: Second attribute word, for both buffers: timing control in bit 3 and space attribute in bits 2:0. Bits 31:4 read as zero.
- R6: An entry has a single valid flag. A write through the tag word or the first attribute word sets that flag, and the flag reads back in bit 8 of both words.
- R7: Every accepted access to either unified array, read or write, advances `repl_count` by one. An access to the instruction buffer leaves it unchanged.
- R8: When `repl_count` is at the last unified index (63), or when `repl_bound` is nonzero and `repl_count + 1` equals `repl_bound`, the next advance sets it to 0.
- R9: A write to a tag word or a first attribute word whose target entry is currently valid makes `flush_valid` high for exactly the cycle after acceptance, with `flush_vpn` holding the old page number. A write to an invalid entry, a write to a second attribute word, or a read gives no pulse.
- R10: Handshake. The response comes on the cycle after acceptance and carries the read data, or zero for a write. While `rsp_valid && !rsp_ready`, `req_ready` is low and `rsp_data` does not change.
- R11: After reset, every entry reads as all zeros (invalid), `repl_count` is 0, and `rsp_valid` and `flush_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Array, half and entry select |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read word, zero for writes |
| repl_bound | input | 6 | Counter wrap point, 0 = no early wrap |
| repl_count | output | 6 | Unified replacement counter |
| flush_valid | output | 1 | One-cycle invalidate notice |
| flush_vpn | output | 22 | Old page number of the overwritten entry |

## Verification
The bench writes all-ones words into every array kind and reads them back. This exposes any unused or missing field bit: a swapped size bit, a stored dirty bit in the instruction buffer, or a leak into bits 29 to 31 would each return a wrong mask. It drives an instruction index with high address bits set to catch a decoder that reads too many index bits. It then walks the counter through the 63-to-0 wrap and a programmed boundary; a design that compared against the bound off by one, or counted instruction accesses, would drift from the expected value. The flush tests cover a first write to an invalid entry, an overwrite, invalidation through the attribute word, and a second-word write. A design that flushed on the new page number, or pulsed on invalid entries, would show a wrong or extra notice. A stalled response checks that the data holds and that no second request slips in.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  typedef enum logic [1:0] {
    FLD_TAG  = 2'd0,
    FLD_ATTR = 2'd1,
    FLD_EXT  = 2'd2
  } fld_e;

  typedef struct packed {
    logic [21:0] vpn;
    logic [7:0]  asid;
    logic        v;
    logic [18:0] ppn;
    logic [1:0]  sz;
    logic [1:0]  pr;
    logic        c;
    logic        d;
    logic        sh;
    logic        wt;
    logic        tc;
    logic [2:0]  sa;
  } tlb_ent_t;

  localparam int unsigned IDX_LSB = 8;

  function automatic tlb_ent_t ent_write(tlb_ent_t cur, fld_e kind,
                                         logic [31:0] w, logic is_insn);
    tlb_ent_t n;
    n = cur;
    case (kind)
      FLD_TAG: begin
        n.vpn  = w[31:10];
        n.v    = w[8];
        n.asid = w[7:0];
      end
      FLD_ATTR: begin
        n.ppn = w[28:10];
        n.v   = w[8];
        n.sz  = {w[7], w[4]};
        n.pr  = is_insn ? {w[6], 1'b0} : w[6:5];
        n.c   = w[3];
        n.d   = is_insn ? 1'b0 : w[2];
        n.sh  = w[1];
        n.wt  = is_insn ? 1'b0 : w[0];
      end
      default: begin
        n.tc = w[3];
        n.sa = w[2:0];
      end
    endcase
    return n;
  endfunction

  function automatic logic [31:0] ent_read(tlb_ent_t e, fld_e kind);
    logic [31:0] r;
    case (kind)
      FLD_TAG:  r = {e.vpn, 1'b0, e.v, e.asid};
      FLD_ATTR: r = {3'b000, e.ppn, 1'b0, e.v, e.sz[1], e.pr[1], e.pr[0],
                     e.sz[0], e.c, e.d, e.sh, e.wt};
      default:  r = {28'd0, e.tc, e.sa};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tlbp_addr_dec.sv
module tlbp_addr_dec
  import tlbp_pkg::*;
#(
  parameter int unsigned I_IDX_W = 2,
  parameter int unsigned U_IDX_W = 6
) (
  input  logic [31:0]        addr,
  output logic               is_unified,
  output fld_e               kind,
  output logic [I_IDX_W-1:0] idx_i,
  output logic [U_IDX_W-1:0] idx_u
);
  logic unused_addr;

  assign is_unified  = addr[25];
  assign kind        = !addr[24] ? FLD_TAG : (addr[23] ? FLD_EXT : FLD_ATTR);
  assign idx_i       = addr[IDX_LSB +: I_IDX_W];
  assign idx_u       = addr[IDX_LSB +: U_IDX_W];
  assign unused_addr = ^addr;
endmodule

// File: rtl/tlbp_entry_bank.sv
module tlbp_entry_bank
  import tlbp_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter bit          IS_INSN = 1'b1,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  fld_e             kind,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             old_v,
  output logic [21:0]      old_vpn
);
  tlb_ent_t ent_q [ENTRIES];
  tlb_ent_t sel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [IDX_W-1:0] EI = IDX_W'(e);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_en && idx == EI) begin
        ent_q[e] <= ent_write(ent_q[e], kind, wdata, IS_INSN);
      end
    end
  end

  assign sel     = ent_q[idx];
  assign rdata   = ent_read(sel, kind);
  assign old_v   = sel.v;
  assign old_vpn = sel.vpn;
endmodule

// File: rtl/tlbp_repl_ctr.sv
module tlbp_repl_ctr #(
  parameter int unsigned WIDTH = 6,
  parameter int unsigned LAST  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WIDTH-1:0] bound,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);
  logic [WIDTH-1:0] inc;
  logic             wrap;

  assign inc  = count + WIDTH'(1);
  assign wrap = (count == LAST_V) || (bound != '0 && inc == bound);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= wrap ? '0 : inc;
  end
endmodule

// File: rtl/tlbp_array_port.sv
module tlbp_array_port
  import tlbp_pkg::*;
#(
  parameter int unsigned I_ENTRIES = 4,
  parameter int unsigned U_ENTRIES = 64,
  localparam int unsigned I_IDX_W  = $clog2(I_ENTRIES),
  localparam int unsigned U_IDX_W  = $clog2(U_ENTRIES),
  localparam int unsigned CNT_W    = U_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data,
  input  logic [CNT_W-1:0] repl_bound,
  output logic [CNT_W-1:0] repl_count,
  output logic             flush_valid,
  output logic [21:0]      flush_vpn
);
  logic               is_u;
  fld_e               kind;
  logic [I_IDX_W-1:0] idx_i;
  logic [U_IDX_W-1:0] idx_u;
  logic               acc;
  logic [31:0]        rd_i, rd_u;
  logic               ov_i, ov_u;
  logic [21:0]        ovpn_i, ovpn_u;
  logic               hit_flush;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  tlbp_addr_dec #(.I_IDX_W(I_IDX_W), .U_IDX_W(U_IDX_W)) dec_i (
    .addr(req_addr), .is_unified(is_u), .kind(kind),
    .idx_i(idx_i), .idx_u(idx_u)
  );

  tlbp_entry_bank #(.ENTRIES(I_ENTRIES), .IS_INSN(1'b1)) ibank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc && req_write && !is_u),
    .idx(idx_i), .kind(kind), .wdata(req_wdata),
    .rdata(rd_i), .old_v(ov_i), .old_vpn(ovpn_i)
  );

  tlbp_entry_bank #(.ENTRIES(U_ENTRIES), .IS_INSN(1'b0)) ubank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc && req_write && is_u),
    .idx(idx_u), .kind(kind), .wdata(req_wdata),
    .rdata(rd_u), .old_v(ov_u), .old_vpn(ovpn_u)
  );

  tlbp_repl_ctr #(.WIDTH(CNT_W), .LAST(U_ENTRIES - 1)) ctr_i (
    .clk(clk), .rst_n(rst_n), .step(acc && is_u),
    .bound(repl_bound), .count(repl_count)
  );

  assign hit_flush = acc && req_write && kind != FLD_EXT && (is_u ? ov_u : ov_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      flush_valid <= 1'b0;
      flush_vpn   <= '0;
    end else begin
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= req_write ? '0 : (is_u ? rd_u : rd_i);
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      flush_valid <= hit_flush;
      if (hit_flush) flush_vpn <= is_u ? ovpn_u : ovpn_i;
    end
  end
endmodule

// File: rtl/tlbp_array_port_chk.sv
module tlbp_array_port_chk #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned LAST  = 63
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [31:0]      req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_data,
  input logic [CNT_W-1:0] repl_bound,
  input logic [CNT_W-1:0] repl_count,
  input logic             flush_valid
);
  logic acc, acc_u;
  assign acc   = req_valid && req_ready;
  assign acc_u = acc && req_addr[25];

  AST_RSP_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_NO_ACC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
  AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_u |=> $stable(repl_count)); // R7
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_u && repl_bound == '0 && repl_count != CNT_W'(LAST))
      |=> repl_count == $past(repl_count) + CNT_W'(1)); // R7
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_u && repl_count == CNT_W'(LAST)) |=> repl_count == '0); // R8
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(acc && req_write && !(req_addr[24] && req_addr[23]))); // R9
endmodule

bind tlbp_array_port tlbp_array_port_chk #(.CNT_W(CNT_W), .LAST(U_ENTRIES - 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .repl_bound(repl_bound),
  .repl_count(repl_count), .flush_valid(flush_valid)
);

// File: tb/tlbp_array_port_tb_top.sv
`timescale 1ns/1ps
module tlbp_array_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, flush_valid;
  logic [31:0] rsp_data;
  logic [5:0]  repl_bound = '0, repl_count;
  logic [21:0] flush_vpn;

  int errors = 0, checks = 0, cycles = 0;
  logic [5:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  tlbp_array_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .repl_bound(repl_bound), .repl_count(repl_count),
    .flush_valid(flush_valid), .flush_vpn(flush_vpn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] arr, logic half, logic [5:0] idx);
    return {6'd0, arr, half, 9'd0, idx, 8'd0};
  endfunction

  function automatic void bump();
    if (exp_cnt == 6'd63 || (repl_bound != 0 && exp_cnt + 6'd1 == repl_bound))
      exp_cnt = 0;
    else
      exp_cnt = exp_cnt + 6'd1;
  endfunction

  // One access; samples response and flush in the cycle after acceptance.
  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic fv, output logic [21:0] fvpn);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_data; fv = flush_valid; fvpn = flush_vpn;
    if (a[25]) bump();
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic fv; logic [21:0] fp;
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R11 flush_valid", {31'd0, flush_valid}, 0);
    chk("R11 count", {26'd0, repl_count}, 0);
    chk("R10 req_ready", {31'd0, req_ready}, 1);
    access(0, mk(2'd3, 0, 6'd17), 0, rd, fv, fp);
    chk("R11 unified attr zero", rd, 0);
    access(0, mk(2'd0, 0, 6'd2), 0, rd, fv, fp);
    chk("R11 insn tag zero", rd, 0);
  endtask

  task automatic t_formats();
    logic [31:0] rd; logic fv; logic [21:0] fp;
    access(1, mk(2'd2, 0, 6'd40), 32'hFFFF_FFFF, rd, fv, fp);
    chk("R10 write rsp zero", rd, 0);
    access(0, mk(2'd2, 0, 6'd40), 0, rd, fv, fp);
    chk("R2 unified tag", rd, 32'hFFFF_FDFF);
    access(1, mk(2'd3, 0, 6'd41), 32'hFFFF_FFFF, rd, fv, fp);
    access(0, mk(2'd3, 0, 6'd41), 0, rd, fv, fp);
    chk("R3 unified attr", rd, 32'h1FFF_FDFF);
    access(1, mk(2'd3, 0, 6'd42), 32'h0000_0090, rd, fv, fp);
    access(0, mk(2'd3, 0, 6'd42), 0, rd, fv, fp);
    chk("R3 size bits", rd, 32'h0000_0090);
    access(1, mk(2'd1, 0, 6'd1), 32'hFFFF_FFFF, rd, fv, fp);
    access(0, mk(2'd1, 0, 6'd1), 0, rd, fv, fp);
    chk("R4 insn attr", rd, 32'h1FFF_FDDA);
    access(1, mk(2'd1, 1, 6'd1), 32'hFFFF_FFFF, rd, fv, fp);
    access(0, mk(2'd1, 1, 6'd1), 0, rd, fv, fp);
    chk("R5 insn ext", rd, 32'h0000_000F);
    access(1, mk(2'd3, 1, 6'd43), 32'h1234_5675, rd, fv, fp);
    access(0, mk(2'd3, 1, 6'd43), 0, rd, fv, fp);
    chk("R5 unified ext", rd, 32'h0000_0005);
  endtask

  task automatic t_valid_share();
    logic [31:0] rd; logic fv; logic [21:0] fp;
    access(1, mk(2'd2, 0, 6'd7), 32'h0000_0500, rd, fv, fp);
    access(0, mk(2'd3, 0, 6'd7), 0, rd, fv, fp);
    chk("R6 valid via tag", rd, 32'h0000_0100);
    access(1, mk(2'd1, 0, 6'd0), 32'h0000_0100, rd, fv, fp);
    access(0, mk(2'd0, 0, 6'd0), 0, rd, fv, fp);
    chk("R6 valid via attr", rd, 32'h0000_0100);
  endtask

  task automatic t_decode();
    logic [31:0] rd; logic fv; logic [21:0] fp;
    access(1, mk(2'd0, 0, 6'd3) | 32'hFC7F_3000, 32'hABCD_E0AA, rd, fv, fp);
    access(0, mk(2'd0, 0, 6'd3), 0, rd, fv, fp);
    chk("R1 insn index bits", rd, 32'hABCD_E0AA);
    access(1, mk(2'd2, 0, 6'd63), 32'h0000_0C11, rd, fv, fp);
    access(0, mk(2'd2, 0, 6'd0), 0, rd, fv, fp);
    chk("R1 unified idx 0 separate", rd, 0);
    access(0, mk(2'd2, 0, 6'd63), 0, rd, fv, fp);
    chk("R1 unified idx 63", rd, 32'h0000_0C11);
  endtask

  task automatic t_counter();
    logic [31:0] rd; logic fv; logic [21:0] fp;
    repl_bound = 0;
    chk("R7 count tracks", {26'd0, repl_count}, {26'd0, exp_cnt});
    access(0, mk(2'd0, 0, 6'd0), 0, rd, fv, fp);
    chk("R7 insn no step", {26'd0, repl_count}, {26'd0, exp_cnt});
    while (exp_cnt != 6'd63) access(0, mk(2'd2, 0, 6'd1), 0, rd, fv, fp);
    chk("R7 reach 63", {26'd0, repl_count}, 32'd63);
    access(1, mk(2'd3, 1, 6'd2), 0, rd, fv, fp);
    chk("R8 wrap after 63", {26'd0, repl_count}, 0);
    repl_bound = 6'd3;
    access(0, mk(2'd3, 0, 6'd2), 0, rd, fv, fp);
    chk("R7 step 1", {26'd0, repl_count}, 1);
    access(0, mk(2'd2, 0, 6'd2), 0, rd, fv, fp);
    chk("R7 step 2", {26'd0, repl_count}, 2);
    access(0, mk(2'd2, 0, 6'd2), 0, rd, fv, fp);
    chk("R8 wrap at bound", {26'd0, repl_count}, 0);
    repl_bound = 0;
  endtask

  task automatic t_flush();
    logic [31:0] rd; logic fv; logic [21:0] fp;
    access(1, mk(2'd2, 0, 6'd5), {22'h0A5A5A, 2'b01, 8'h11}, rd, fv, fp);
    chk("R9 no flush invalid", {31'd0, fv}, 0);
    access(1, mk(2'd2, 0, 6'd5), {22'h135791, 2'b01, 8'h22}, rd, fv, fp);
    chk("R9 flush on overwrite", {31'd0, fv}, 1);
    chk("R9 old vpn", {10'd0, fp}, 32'h000A_5A5A);
    @(negedge clk);
    chk("R9 one-cycle pulse", {31'd0, flush_valid}, 0);
    access(1, mk(2'd3, 1, 6'd5), 32'hF, rd, fv, fp);
    chk("R9 no flush ext", {31'd0, fv}, 0);
    access(0, mk(2'd2, 0, 6'd5), 0, rd, fv, fp);
    chk("R9 no flush read", {31'd0, fv}, 0);
    access(1, mk(2'd3, 0, 6'd5), 0, rd, fv, fp);
    chk("R9 flush via attr", {31'd0, fv}, 1);
    chk("R9 attr old vpn", {10'd0, fp}, 32'h0013_5791);
    access(1, mk(2'd3, 0, 6'd5), 0, rd, fv, fp);
    chk("R9 no flush now invalid", {31'd0, fv}, 0);
    access(1, mk(2'd0, 0, 6'd2), {22'h3FFFFE, 2'b01, 8'h0}, rd, fv, fp);
    access(1, mk(2'd1, 0, 6'd2), 32'h0, rd, fv, fp);
    chk("R9 insn flush", {31'd0, fv}, 1);
    chk("R9 insn old vpn", {10'd0, fp}, 32'h003F_FFFE);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = mk(2'd2, 0, 6'd63); rsp_ready = 0;
    @(posedge clk);
    @(negedge clk);
    bump();
    chk("R10 rsp valid", {31'd0, rsp_valid}, 1);
    first = rsp_data;
    chk("R10 read data", first, 32'h0000_0C11);
    req_addr = mk(2'd0, 0, 6'd3);
    chk("R10 ready low stall", {31'd0, req_ready}, 0);
    @(negedge clk);
    chk("R10 held valid", {31'd0, rsp_valid}, 1);
    chk("R10 held data", rsp_data, first);
    chk("R7 no step while stalled", {26'd0, repl_count}, {26'd0, exp_cnt});
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 second rsp", rsp_data, 32'hABCD_E0AA);
    @(negedge clk);
    chk("R10 rsp drained", {31'd0, rsp_valid}, 0);
    chk("R7 count after stall", {26'd0, repl_count}, {26'd0, exp_cnt});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_valid_share();
    t_decode();
    t_counter();
    t_flush();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule